// File: doc/BRIEF.md
# Elapsed-Time Counter with Alarm and Interval Timers

This block keeps time for a low-power clock domain. A 48-bit up-counter advances by one on every cycle where the 32.768 kHz tick enable is high. Its lowest 16 bits therefore wrap every two seconds, and the upper 32 bits count two-second units. Software reaches the counter through a 16-bit register port as three pieces and may overwrite any piece at any time. A 48-bit alarm value raises a status flag when the counter arrives at it.

Two independent interval timers each count down from a 32-bit period. On expiry a timer reloads and raises its own status flag. A period of 256 gives a steady 128 Hz system tick. The three status flags are sticky and are cleared by writing ones. A single interrupt line is driven from the flags that are enabled in a mask register.

Registers sit at word addresses: elapsed pieces low/mid/high at 0/1/2, alarm pieces at 3/4/5, and timer k at 6+4k. Each timer block holds period low, period high, count low and count high, in that order. Status is at 14 and mask at 15. Status and mask bits are bit 0 alarm, bit 1 timer 0 and bit 2 timer 1. Reads are combinational in the same cycle.

Top module: `rtc_timer_block`

## Requirements
- R1: After reset every register at addresses 0 to 15 reads zero and `irq` is low.
- R2: Each cycle with `tick_en` high and no write to addresses 0–2 adds one to the 48-bit counter, with carry through all three 16-bit pieces and wrap at 2^48. Without a tick the counter holds.
- R3: A write to address 0, 1 or 2 replaces that 16-bit piece on the next edge. If `tick_en` is high in the same cycle, the counter becomes the written value plus one, so that tick is neither lost nor counted twice.
- R4: Status bit 0 sets on the edge where a tick (with no elapsed write) moves the counter onto the alarm value at addresses 3–5. An alarm value of zero never sets it, even when the counter wraps to zero.
- R5: With a nonzero period, a timer sets its status bit (bit 1 for timer 0, bit 2 for timer 1) on exactly every Nth tick and reloads N. A write to either period piece loads the new period into the countdown.
- R6: A timer whose period is zero holds its count at zero and never sets its status bit.
- R7: The count registers (addresses 8/9 and 12/13) read the live countdown, which falls by one per tick. Writes to them have no effect.
- R8: Writing a one to a status bit at address 14 clears it, and zero bits leave their flags untouched. An event arriving in the same cycle as its clear leaves the bit set.
- R9: `irq` is high exactly when some status bit and its mask bit at address 15 are both one.
- R10: Loading timer 0 with period low 256 and high 0 raises a masked-in interrupt after exactly 256 ticks, and again 256 ticks after each clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | 32.768 kHz count enable, one cycle wide |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 4 | Word address of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt, OR of enabled status bits |

## Verification
The bench forces the carry chain by parking the counter at all-ones in the low and mid pieces, and again at the 48-bit maximum. A broken carry would leave the high piece stale, and a zero alarm that was not suppressed would fire on the wrap. It drives a write and a tick in the same cycle, so a design that drops or doubles that tick reads one off. It also lands a status clear on the same cycle as an alarm hit, where a clear-wins design would lose the event. The 128 Hz case counts ticks to the interrupt, so an off-by-one reload shows up as 255 or 257. Random traffic with short periods and near alarms then compares every register against a bench model.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // Status and mask bit positions
  localparam int ST_ALARM = 0;
  localparam int ST_TMR0  = 1;
endpackage

// File: rtl/rtc_elapsed.sv
module rtc_elapsed #(
  parameter int REG_W  = 16,
  parameter int PIECES = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_en,
  input  logic [PIECES-1:0]       cnt_wr,
  input  logic [PIECES-1:0]       cmp_wr,
  input  logic [REG_W-1:0]        wdata,
  output logic [REG_W*PIECES-1:0] cnt_o,
  output logic [REG_W*PIECES-1:0] cmp_o,
  output logic                    hit_o
);
  localparam int W = REG_W * PIECES;

  logic [W-1:0] cnt_q, cnt_d, merged, cmp_q, cmp_d;
  logic         cnt_en, cmp_en, any_wr;

  always_comb begin
    merged = cnt_q;
    cmp_d  = cmp_q;
    for (int i = 0; i < PIECES; i++) begin
      if (cnt_wr[i]) merged[i*REG_W +: REG_W] = wdata;
      if (cmp_wr[i]) cmp_d[i*REG_W +: REG_W]  = wdata;
    end
    any_wr = |cnt_wr;
    cnt_d  = merged + W'(tick_en);
    cnt_en = tick_en | any_wr;
    cmp_en = |cmp_wr;
    hit_o  = tick_en && !any_wr && (cmp_q != '0) && ((cnt_q + W'(1)) == cmp_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (cmp_en) cmp_q <= cmp_d;
    end
  end

  assign cnt_o = cnt_q;
  assign cmp_o = cmp_q;

  // R2
  tick_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !any_wr) |=> (cnt_q == $past(cnt_q) + W'(1)));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !any_wr) |=> $stable(cnt_q));
  // R4
  hit_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> (cnt_q == $past(cmp_q)));
endmodule

// File: rtl/rtc_interval.sv
module rtc_interval #(
  parameter int REG_W  = 16,
  parameter int PIECES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_en,
  input  logic [PIECES-1:0]       per_wr,
  input  logic [REG_W-1:0]        wdata,
  output logic [REG_W*PIECES-1:0] per_o,
  output logic [REG_W*PIECES-1:0] cnt_o,
  output logic                    expire_o
);
  localparam int W = REG_W * PIECES;

  logic [W-1:0] per_q, per_d, cnt_q, cnt_d;
  logic         any_wr;

  always_comb begin
    per_d = per_q;
    for (int i = 0; i < PIECES; i++)
      if (per_wr[i]) per_d[i*REG_W +: REG_W] = wdata;
    any_wr   = |per_wr;
    cnt_d    = cnt_q;
    expire_o = 1'b0;
    if (any_wr) begin
      cnt_d = per_d;
    end else if (per_q == '0) begin
      cnt_d = '0;
    end else if (tick_en) begin
      if (cnt_q <= W'(1)) begin
        cnt_d    = per_q;
        expire_o = 1'b1;
      end else begin
        cnt_d = cnt_q - W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      cnt_q <= '0;
    end else begin
      if (any_wr) per_q <= per_d;
      cnt_q <= cnt_d;
    end
  end

  assign per_o = per_q;
  assign cnt_o = cnt_q;

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (cnt_q == $past(per_q)));
  // R6
  zero_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((per_q == '0) && !any_wr) |=> (cnt_q == '0));
  // R5
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((per_q != '0) && !tick_en && !any_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_timer_block.sv
module rtc_timer_block #(
  parameter int REG_W     = 16,
  parameter int EL_PIECES = 3,
  parameter int TM_PIECES = 2,
  parameter int N_TMR     = 2,
  parameter int ADDR_W    = $clog2(2*EL_PIECES + 2*N_TMR*TM_PIECES + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              irq
);
  import rtc_pkg::*;

  localparam int EL_W      = REG_W * EL_PIECES;
  localparam int TM_W      = REG_W * TM_PIECES;
  localparam int CMP_BASE  = EL_PIECES;
  localparam int TMR_BASE  = 2 * EL_PIECES;
  localparam int TMR_SPAN  = 2 * TM_PIECES;
  localparam int STAT_ADDR = TMR_BASE + N_TMR * TMR_SPAN;
  localparam int MASK_ADDR = STAT_ADDR + 1;
  localparam int N_SRC     = 1 + N_TMR;

  // reset: asynchronous assert, synchronous release
  logic rst_s1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  logic [EL_PIECES-1:0]                el_wr, cmp_wr;
  logic [N_TMR-1:0][TM_PIECES-1:0]     per_wr;
  logic [EL_W-1:0]                     el_cnt, el_cmp;
  logic [N_TMR-1:0][TM_W-1:0]          tm_per, tm_cnt;
  logic [N_TMR-1:0]                    tm_exp;
  logic                                cmp_hit, stat_wr, mask_wr;
  logic [N_SRC-1:0]                    stat_q, stat_d, mask_q, mask_d, src, clr;

  always_comb begin
    for (int i = 0; i < EL_PIECES; i++) begin
      el_wr[i]  = wr_en && (addr == ADDR_W'(i));
      cmp_wr[i] = wr_en && (addr == ADDR_W'(CMP_BASE + i));
    end
    for (int k = 0; k < N_TMR; k++)
      for (int j = 0; j < TM_PIECES; j++)
        per_wr[k][j] = wr_en && (addr == ADDR_W'(TMR_BASE + k*TMR_SPAN + j));
    stat_wr = wr_en && (addr == ADDR_W'(STAT_ADDR));
    mask_wr = wr_en && (addr == ADDR_W'(MASK_ADDR));
  end

  rtc_elapsed #(.REG_W(REG_W), .PIECES(EL_PIECES)) u_elapsed (
    .clk(clk), .rst_n(rst_sync_n), .tick_en(tick_en),
    .cnt_wr(el_wr), .cmp_wr(cmp_wr), .wdata(wdata),
    .cnt_o(el_cnt), .cmp_o(el_cmp), .hit_o(cmp_hit)
  );

  for (genvar k = 0; k < N_TMR; k++) begin : g_tmr
    rtc_interval #(.REG_W(REG_W), .PIECES(TM_PIECES)) u_interval (
      .clk(clk), .rst_n(rst_sync_n), .tick_en(tick_en),
      .per_wr(per_wr[k]), .wdata(wdata),
      .per_o(tm_per[k]), .cnt_o(tm_cnt[k]), .expire_o(tm_exp[k])
    );
  end

  // sticky status: set wins over a same-cycle clear
  always_comb begin
    src    = {tm_exp, cmp_hit};
    clr    = stat_wr ? wdata[N_SRC-1:0] : '0;
    stat_d = (stat_q & ~clr) | src;
    mask_d = mask_wr ? wdata[N_SRC-1:0] : mask_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= stat_d;
      if (mask_wr) mask_q <= mask_d;
    end
  end

  assign irq = |(stat_q & mask_q);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < EL_PIECES; i++) begin
      if (addr == ADDR_W'(i))            rdata = el_cnt[i*REG_W +: REG_W];
      if (addr == ADDR_W'(CMP_BASE + i)) rdata = el_cmp[i*REG_W +: REG_W];
    end
    for (int k = 0; k < N_TMR; k++)
      for (int j = 0; j < TM_PIECES; j++) begin
        if (addr == ADDR_W'(TMR_BASE + k*TMR_SPAN + j))
          rdata = tm_per[k][j*REG_W +: REG_W];
        if (addr == ADDR_W'(TMR_BASE + k*TMR_SPAN + TM_PIECES + j))
          rdata = tm_cnt[k][j*REG_W +: REG_W];
      end
    if (addr == ADDR_W'(STAT_ADDR)) rdata = REG_W'(stat_q);
    if (addr == ADDR_W'(MASK_ADDR)) rdata = REG_W'(mask_q);
  end

  // R8
  sticky_stat_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !stat_wr |=> (($past(stat_q) & ~stat_q) == '0));
  // R9
  mask_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mask_q == '0) |-> !irq);
  // R4
  alarm_bit_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmp_hit |=> stat_q[ST_ALARM]);
  // R5
  tmr0_bit_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tm_exp[0] |=> stat_q[ST_TMR0]);
endmodule

// File: tb/test_rtc_timer_block.sv
module test_rtc_timer_block;
  localparam int A_STAT = 14, A_MASK = 15;

  logic        clk = 1'b0;
  logic        rst_n, tick_en, wr_en, irq;
  logic [3:0]  addr;
  logic [15:0] wdata, rdata;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [47:0] m_el, m_cmp;
  logic [31:0] m_per [2];
  logic [31:0] m_cnt [2];
  logic [2:0]  m_st, m_mask;

  always #5 clk = ~clk;

  rtc_timer_block i_rtc_timer_block (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_rd(input int a);
    case (a)
      0, 1, 2:        return m_el[a*16 +: 16];
      3, 4, 5:        return m_cmp[(a-3)*16 +: 16];
      6, 7:           return m_per[0][(a-6)*16 +: 16];
      8, 9:           return m_cnt[0][(a-8)*16 +: 16];
      10, 11:         return m_per[1][(a-10)*16 +: 16];
      12, 13:         return m_cnt[1][(a-12)*16 +: 16];
      14:             return {13'd0, m_st};
      default:        return {13'd0, m_mask};
    endcase
  endfunction

  // reference behaviour from the requirements, one clock edge
  task automatic model_step(input bit tk, input bit we, input int a, input logic [15:0] d);
    logic [47:0] mrg = m_el;
    logic [2:0]  src = 3'b0, clr = 3'b0;
    bit el_w = we && (a <= 2);
    if (el_w) mrg[a*16 +: 16] = d;
    src[0] = tk && !el_w && (m_cmp != 0) && ((m_el + 48'd1) == m_cmp);
    m_el = mrg + 48'(tk);
    if (we && a >= 3 && a <= 5) m_cmp[(a-3)*16 +: 16] = d;
    for (int k = 0; k < 2; k++) begin
      int base = 6 + 4*k;
      if (we && (a == base || a == base + 1)) begin
        m_per[k][(a-base)*16 +: 16] = d;
        m_cnt[k] = m_per[k];
      end else if (m_per[k] == 0) begin
        m_cnt[k] = 0;
      end else if (tk) begin
        if (m_cnt[k] <= 1) begin
          m_cnt[k] = m_per[k];
          src[k+1] = 1'b1;
        end else m_cnt[k] = m_cnt[k] - 1;
      end
    end
    if (we && a == A_STAT) clr = d[2:0];
    m_st = (m_st & ~clr) | src;
    if (we && a == A_MASK) m_mask = d[2:0];
  endtask

  task automatic cyc(input bit tk, input bit we, input int a, input logic [15:0] d);
    tick_en = tk; wr_en = we; addr = 4'(a); wdata = d;
    model_step(tk, we, a, d);
    @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    wr_en = 1'b0; tick_en = 1'b0; addr = 4'(a);
    #1 v = rdata;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic check_all(input string req);
    for (int a = 0; a < 16; a++) rd_chk(req, a, model_rd(a));
    chk(req, irq, |(m_st & m_mask));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int got;
    void'($urandom(32'h5eed_0042));
    m_el = 0; m_cmp = 0; m_st = 0; m_mask = 0;
    for (int k = 0; k < 2; k++) begin m_per[k] = 0; m_cnt[k] = 0; end
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; addr = 4'd0; wdata = 16'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check_all("R1");

    // R2 carry through all pieces
    cyc(0, 1, 0, 16'hFFFF); cyc(0, 1, 1, 16'hFFFF); cyc(0, 1, 2, 16'h0012);
    cyc(1, 0, 0, 0);
    rd_chk("R2", 0, 16'h0000); rd_chk("R2", 1, 16'h0000); rd_chk("R2", 2, 16'h0013);

    // R3 write and tick in one cycle
    cyc(1, 1, 0, 16'h0100);
    rd_chk("R3", 0, 16'h0101);
    repeat (3) cyc(0, 0, 0, 0);
    rd_chk("R2", 0, 16'h0101);

    // R4 alarm hit
    cyc(0, 1, 0, 0); cyc(0, 1, 1, 0); cyc(0, 1, 2, 0);
    cyc(0, 1, 3, 16'd5); cyc(0, 1, 4, 0); cyc(0, 1, 5, 0);
    cyc(0, 1, A_STAT, 16'h7);
    repeat (4) cyc(1, 0, 0, 0);
    rd_chk("R4", A_STAT, 16'h0);
    cyc(1, 0, 0, 0);
    rd_chk("R4", A_STAT, 16'h1);
    rd_chk("R4", 0, 16'd5);

    // R4 zero alarm ignored on wrap to zero
    cyc(0, 1, 3, 0);
    cyc(0, 1, 0, 16'hFFFF); cyc(0, 1, 1, 16'hFFFF); cyc(0, 1, 2, 16'hFFFF);
    cyc(0, 1, A_STAT, 16'h7);
    cyc(1, 0, 0, 0);
    rd_chk("R2", 2, 16'h0000);
    rd_chk("R4", A_STAT, 16'h0);

    // R8 set wins over same-cycle clear; zero bits keep flags
    cyc(0, 1, 3, 16'd9);
    cyc(0, 1, 0, 16'd8);
    cyc(1, 1, A_STAT, 16'h1);
    rd_chk("R8", A_STAT, 16'h1);
    cyc(0, 1, A_STAT, 16'h6);
    rd_chk("R8", A_STAT, 16'h1);
    cyc(0, 1, A_STAT, 16'h1);
    rd_chk("R8", A_STAT, 16'h0);

    // R6 zero period, R7 count writes ignored
    cyc(0, 1, 3, 0);
    cyc(0, 1, 6, 0); cyc(0, 1, 7, 0);
    cyc(0, 1, 8, 16'hABCD);
    repeat (20) cyc(1, 0, 0, 0);
    rd_chk("R6", 8, 16'h0);
    rd_chk("R7", 8, 16'h0);
    rd_chk("R6", A_STAT, 16'h0);

    // R10 128 Hz tick, R7 live countdown
    cyc(0, 1, A_MASK, 16'h2);
    cyc(0, 1, 7, 0); cyc(0, 1, 6, 16'd256);
    got = 0;
    for (int n = 1; n <= 300; n++) begin
      if (n == 50) cyc(1, 1, 8, 16'h0001); else cyc(1, 0, 0, 0);
      if (n == 100) begin
        rd_chk("R7", 8, 16'd156);
        rd_chk("R7", 9, 16'd0);
      end
      if (irq && got == 0) got = n;
      if (got != 0) break;
    end
    chk("R10", got, 256);
    cyc(0, 1, A_STAT, 16'h2);
    chk("R8", irq, 1'b0);
    got = 0;
    for (int n = 1; n <= 300; n++) begin
      cyc(1, 0, 0, 0);
      if (irq) begin got = n; break; end
    end
    chk("R10", got, 256);

    // R9 masking
    cyc(0, 1, A_MASK, 16'h0);
    chk("R9", irq, 1'b0);
    cyc(0, 1, A_MASK, 16'h2);
    chk("R9", irq, 1'b1);

    // R5 timer 1, period 3
    cyc(0, 1, 11, 0); cyc(0, 1, 10, 16'd3);
    cyc(0, 1, A_MASK, 16'h4); cyc(0, 1, A_STAT, 16'h7);
    repeat (2) cyc(1, 0, 0, 0);
    rd(A_STAT, v); chk("R5", v[2], 1'b0);
    cyc(1, 0, 0, 0);
    rd(A_STAT, v); chk("R5", v[2], 1'b1);
    chk("R9", irq, 1'b1);
    rd_chk("R5", 12, 16'd3);

    // random traffic against the model
    check_all("R5");
    for (int i = 0; i < 4000; i++) begin
      bit tk = ($urandom_range(0, 1) == 1);
      bit we = ($urandom_range(0, 7) == 0);
      int a  = $urandom_range(0, 15);
      logic [15:0] d = 16'($urandom);
      logic [47:0] near;
      if (a == 6 || a == 10) d = 16'($urandom_range(0, 12));
      if (a == 7 || a == 11) d = ($urandom_range(0, 7) == 0) ? 16'd1 : 16'd0;
      if (a >= 3 && a <= 5) begin
        near = m_el + 48'($urandom_range(1, 40));
        d = near[(a-3)*16 +: 16];
      end
      if (a == 0 && $urandom_range(0, 3) == 0) d = 16'hFFFE;
      cyc(tk, we, a, d);
      if (i % 100 == 99) check_all("R2 R3 R4 R5 R7 R8 R9");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule